// File: doc/BRIEF.md
# I2C Own-Address Register and Address Matcher

This block keeps the device's own I2C target address in a 32-bit configuration word and decides, for every received target address, whether the device answers with ACK or NACK. Software writes and reads the word over a simple bus-clock port. A receiver front end, which sits outside this block, supplies an already assembled address. That address is either a 7-bit value or a 10-bit value gathered from the header byte and the second byte, and a flag gives its length. A strobe marks it valid. The decision is combinational from the stored word and the received address.

The word has three fields. Bit 15 is the enable. Bit 10 is the size selector, where 0 means 7-bit and 1 means 10-bit. Bits 9:0 hold the address. The size selector and the address field are frozen while the enable reads 1. Each accepted write starts a completion window of `BUSY_CYCLES` clocks. The window is run by a two-state write controller: `WR_IDLE` goes to `WR_BUSY` on an accepted write (transition *accept*), `WR_BUSY` stays put while its down-counter is non-zero (transition *hold*), and `WR_BUSY` goes back to `WR_IDLE` when the counter reaches zero (transition *release*). A write presented during `WR_BUSY` is stalled, because `wr_ready` is low. Reads never stall.

Top module: `i2c_own_addr`

## Requirements
- R1: After reset `rd_data` is 0, `wr_ready` is 1, and `addr_ack` and `addr_nack` are both 0.
- R2: Bits 31:16 and 14:11 of `rd_data` always read 0, and writing 1s to them has no effect. After writing 0xFFFFFFFF while disabled, `rd_data` is 0x000087FF.
- R3: While the enable (bit 15) is 0, a valid received address that equals the stored address gives `addr_nack`=1 and `addr_ack`=0.
- R4: In 7-bit mode (bit 10 = 0), a 7-bit received address is acknowledged when `rx_addr[6:0]` equals stored bits 7:1. Stored bits 9:8 and 0 play no part.
- R5: In 10-bit mode (bit 10 = 1), a 10-bit received address is acknowledged only when all 10 bits equal stored bits 9:0.
- R6: A received address whose length (`rx_is10`) differs from the stored mode is never acknowledged.
- R7: A write accepted while the enable reads 0 loads bits 10:0 from `wr_data`. A write accepted while the enable reads 1 leaves bits 10:0 unchanged, yet still loads bit 15.
- R8: The lock uses the enable value held before the write. A single write that clears the enable and changes the address updates only the enable.
- R9: After an accepted write, `wr_ready` is 0 for exactly `BUSY_CYCLES` cycles (default 3). A write presented while `wr_ready` is 0 is not taken.
- R10: When `rx_valid` is 0, `addr_ack` and `addr_nack` are both 0. When `rx_valid` is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | High when a write can be accepted |
| rd_data | output | 32 | Current register contents |
| rx_valid | input | 1 | Received address strobe |
| rx_is10 | input | 1 | Received address is 10-bit |
| rx_addr | input | 10 | Received address (7-bit value in bits 6:0) |
| addr_ack | output | 1 | Acknowledge the received address |
| addr_nack | output | 1 | Reject the received address |

## Verification
Two functions can meet in one cycle: the enable changes, and the lock decides whether the address fields may change. The bench provokes this with a single write that clears the enable and carries a new address. It then judges at the read port that only the enable moved. The second collision is a write arriving while the completion window is still open. The bench pulses a write during the busy cycles and confirms afterwards that the register still holds the earlier value.

// File: rtl/i2c_oa_pkg.sv
package i2c_oa_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 10;
    localparam int SHORT_W  = 7;
    localparam int EN_POS   = 15;
    localparam int MODE_POS = 10;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;
endpackage

// File: rtl/oa_wr_ctrl.sv
module oa_wr_ctrl #(
    parameter int BUSY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic wr_fire,
    output logic wr_ready
);
    import i2c_oa_pkg::*;

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    wr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wr_ready = 1'b0;
        wr_fire  = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                wr_ready = 1'b1;
                if (wr_en) begin                 // accept
                    wr_fire = 1'b1;
                    state_d = WR_BUSY;
                    cnt_d   = LOAD;
                end
            end
            WR_BUSY: begin
                if (cnt_q == '0) state_d = WR_IDLE;  // release
                else             cnt_d   = cnt_q - 1'b1; // hold
            end
            default: state_d = WR_IDLE;
        endcase
    end
endmodule

// File: rtl/oa_store.sv
module oa_store
    import i2c_oa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [WORD_W-1:0] wr_data,
    output logic              en_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            mode_o <= 1'b0;
            addr_o <= '0;
        end else if (wr_fire) begin
            en_o <= wr_data[EN_POS];
            if (!en_o) begin          // lock judged on the pre-write enable
                mode_o <= wr_data[MODE_POS];
                addr_o <= wr_data[ADDR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/oa_match.sv
module oa_match
    import i2c_oa_pkg::*;
(
    input  logic              en,
    input  logic              mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_valid,
    input  logic              rx_is10,
    input  logic [ADDR_W-1:0] rx_addr,
    output logic              ack,
    output logic              nack
);
    logic [ADDR_W-1:0] own_cmp, rx_cmp;
    logic              hit;

    always_comb begin
        own_cmp = mode    ? own_addr
                          : {{(ADDR_W-SHORT_W){1'b0}}, own_addr[SHORT_W:1]};
        rx_cmp  = rx_is10 ? rx_addr
                          : {{(ADDR_W-SHORT_W){1'b0}}, rx_addr[SHORT_W-1:0]};
        hit     = (mode == rx_is10) && (own_cmp == rx_cmp);
        ack     = rx_valid && en && hit;
        nack    = rx_valid && !(en && hit);
    end
endmodule

// File: rtl/i2c_own_addr.sv
module i2c_own_addr #(
    parameter int BUSY_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    output logic [31:0] rd_data,
    input  logic        rx_valid,
    input  logic        rx_is10,
    input  logic [9:0]  rx_addr,
    output logic        addr_ack,
    output logic        addr_nack
);
    import i2c_oa_pkg::*;

    logic              wr_fire;
    logic              en_q, mode_q;
    logic [ADDR_W-1:0] addr_q;

    oa_wr_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_fire  (wr_fire),
        .wr_ready (wr_ready)
    );

    oa_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_data (wr_data),
        .en_o    (en_q),
        .mode_o  (mode_q),
        .addr_o  (addr_q)
    );

    oa_match u_match (
        .en       (en_q),
        .mode     (mode_q),
        .own_addr (addr_q),
        .rx_valid (rx_valid),
        .rx_is10  (rx_is10),
        .rx_addr  (rx_addr),
        .ack      (addr_ack),
        .nack     (addr_nack)
    );

    always_comb begin
        rd_data                 = '0;
        rd_data[EN_POS]         = en_q;
        rd_data[MODE_POS]       = mode_q;
        rd_data[ADDR_W-1:0]     = addr_q;
    end
endmodule

// File: rtl/oa_checker.sv
module oa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic [31:0] rd_data,
    input logic        rx_valid,
    input logic        rx_is10,
    input logic [9:0]  rx_addr,
    input logic        addr_ack,
    input logic        addr_nack
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0 && rd_data[14:11] == 4'h0);

    p_disabled_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> rd_data[15]);

    p_short_compare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && !rx_is10) |-> rx_addr[6:0] == rd_data[7:1]);

    p_long_compare_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && rx_is10) |-> rx_addr == rd_data[9:0]);

    p_length_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> rx_is10 == rd_data[10]);

    p_open_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && !rd_data[15]) |=> rd_data[10:0] == $past(wr_data[10:0]));

    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && rd_data[15]) |=> $stable(rd_data[10:0]));

    p_busy_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> !wr_ready);

    p_stall_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(rd_data));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> !addr_ack && !addr_nack);

    p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $countones({addr_ack, addr_nack}) == 1);
endmodule

bind i2c_own_addr oa_checker u_chk (.*);

// File: tb/sim_i2c_own_addr.sv
`timescale 1ns/1ps
module sim_i2c_own_addr;
    localparam int BUSY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic [31:0] rd_data;
    logic        rx_valid = 1'b0;
    logic        rx_is10 = 1'b0;
    logic [9:0]  rx_addr = '0;
    logic        addr_ack, addr_nack;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    i2c_own_addr #(.BUSY_CYCLES(BUSY)) u0 (.*);

    // {cfg[10:0], rx_is10, rx_addr, expected ack}
    localparam logic [22:0] VEC [10] = '{
        {11'h0A4, 1'b0, 10'h052, 1'b1},   // R4 basic 7-bit
        {11'h3A5, 1'b0, 10'h052, 1'b1},   // R4 bits 9:8,0 ignored
        {11'h0A4, 1'b0, 10'h053, 1'b0},   // R4 mismatch
        {11'h0A4, 1'b1, 10'h052, 1'b0},   // R6 length differs
        {11'h6C7, 1'b1, 10'h2C7, 1'b1},   // R5 10-bit hit
        {11'h6C7, 1'b1, 10'h2C6, 1'b0},   // R5 low bit differs
        {11'h6C7, 1'b1, 10'h0C7, 1'b0},   // R5 high bits differ
        {11'h6C7, 1'b0, 10'h0C7, 1'b0},   // R6 length differs
        {11'h401, 1'b1, 10'h001, 1'b1},   // R5 bit 0 counts
        {11'h7FF, 1'b1, 10'h3FF, 1'b1}    // R5 all ones
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        while (!wr_ready) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 wr_ready", {31'h0, wr_ready}, 32'h1);
        rx_valid = 1'b1;
        rx_valid = 1'b0;
        check("R1 ack/nack", {30'h0, addr_ack, addr_nack}, 32'h0);

        // vector table
        for (int i = 0; i < 10; i++) begin
            logic [10:0] cfg;
            logic        exp;
            cfg = VEC[i][22:12];
            do_write(32'h0);
            do_write({21'h0, cfg});
            do_write({16'h0, 1'b1, 4'h0, cfg});
            rx_is10  = VEC[i][11];
            rx_addr  = VEC[i][10:1];
            exp      = VEC[i][0];
            rx_valid = 1'b1;
            #1;
            check($sformatf("R4/R5/R6 vec%0d ack", i), {31'h0, addr_ack}, {31'h0, exp});
            check($sformatf("R10 vec%0d nack", i), {31'h0, addr_nack}, {31'h0, ~exp});
            rx_valid = 1'b0;
            #1;
            check($sformatf("R10 vec%0d idle", i), {30'h0, addr_ack, addr_nack}, 32'h0);
        end

        // R2 reserved bits
        do_write(32'h0);
        do_write(32'h0);
        do_write(32'hFFFF_FFFF);
        check("R2 reserved", rd_data, 32'h0000_87FF);

        // R7 locked address, enable stays writable
        do_write(32'h0000_8000);
        check("R7 locked", rd_data, 32'h0000_87FF);

        // R8 clear enable and change address in one write
        do_write(32'h0000_0123);
        check("R8 same-write clear", rd_data, 32'h0000_07FF);
        do_write(32'h0000_0123);
        check("R7 open load", rd_data, 32'h0000_0123);

        // R3 disabled NACKs matching address
        do_write(32'h0000_00A4);
        rx_is10 = 1'b0; rx_addr = 10'h052; rx_valid = 1'b1;
        #1;
        check("R3 ack/nack", {30'h0, addr_ack, addr_nack}, 32'h1);
        rx_valid = 1'b0;

        // R9 busy window length
        wait_idle();
        do_write(32'h0000_0000);
        begin
            int n;
            n = 0;
            while (!wr_ready) begin
                n++;
                @(negedge clk);
            end
            check("R9 busy cycles", n, BUSY);
        end

        // R9 write during busy is not taken
        do_write(32'h0000_0000);
        wr_en = 1'b1; wr_data = 32'h0000_00A4;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        @(negedge clk);
        check("R9 stalled write", rd_data, 32'h0);

        finish_run();
    end
endmodule